// File: doc/BRIEF.md
# Programmable Frame-Sync Pulse Generator

This block produces a periodic frame-synchronization pulse for a serial port. It runs on the system clock. It advances only on cycles where a sample-rate clock enable is high, so one "tick" is one sample-rate clock period. Two configuration inputs set the length of the high phase and the length of the whole frame. Each value is encoded as the length minus one.

Two controls gate the generator: a run control and an automatic-mode select. Pulses are produced only while both are high. When either one falls, the output returns low on the next tick. When both are high again, a fresh frame begins. Configuration changes take effect only at a frame boundary. A frame that is already in progress keeps its original shape.

Top module: `fsync_gen`

## Requirements
- R1: While `rst` is high, and after it has been released, `fs_out` is low until the first tick with both `run` and `auto_en` high.
- R2: On the first tick where `run` and `auto_en` are both high after the generator was idle, `fs_out` goes high. That tick is index 0 of a new frame.
- R3: Within a frame, `fs_out` is high after ticks 0 to `width_cfg` (inclusive), which is `width_cfg + 1` ticks in total. When the frame is long enough, it is low after the remaining ticks.
- R4: A new frame starts every `period_cfg + 1` ticks. In other words, after tick index k since the start, the output equals `(k mod (period_cfg+1)) < (width_cfg+1)`.
- R5: `fs_out` and the counters change only on cycles where `tick` is high. On all other cycles `fs_out` holds its value.
- R6: If `width_cfg + 1 >= period_cfg + 1`, `fs_out` stays high continuously while running. This includes the case `period_cfg = 0`.
- R7: `width_cfg` and `period_cfg` are sampled only at a frame start. A change made in the middle of a frame first shows in the next frame.
- R8: A tick with `run` or `auto_en` low clears the generator, and `fs_out` is low after that tick. The next enabled tick starts a new frame, as in R2.
- R9: The full ranges work: a `width_cfg` of 255 gives a high phase of 256 ticks, and a `period_cfg` of 4095 gives a frame of 4096 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample-rate clock enable |
| run | input | 1 | Generator run control (low holds it cleared) |
| auto_en | input | 1 | Selects automatic periodic frame sync |
| width_cfg | input | WID_W (8) | High-phase length minus one, in ticks |
| period_cfg | input | PER_W (12) | Frame length minus one, in ticks |
| fs_out | output | 1 | Frame-sync pulse |

## Verification
Every result is due on the system clock edge where `tick` is high. It is registered there and can be read one edge later. The bench drives each tick for exactly one clock, starting on a falling edge, and reads `fs_out` on the next falling edge. That sample always belongs to one known tick index, and the bench compares it with the closed-form value from R4. When idle clocks are placed between ticks, the bench samples each of them and requires the output to be unchanged. For the disable and reconfiguration cases, the bench counts tick indices from the edge where the change was applied.

// File: rtl/fsync_gen.sv
module fsync_gen #(
  parameter int WID_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             auto_en,
  input  logic [WID_W-1:0] width_cfg,
  input  logic [PER_W-1:0] period_cfg,
  output logic             fs_out
);

  logic             active;
  logic [WID_W-1:0] wcnt;
  logic [PER_W-1:0] pcnt;

  wire go       = run & auto_en;
  wire boundary = !active || (pcnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      fs_out <= 1'b0;
      wcnt   <= '0;
      pcnt   <= '0;
    end else if (tick) begin
      if (!go) begin
        active <= 1'b0;
        fs_out <= 1'b0;
        wcnt   <= '0;
        pcnt   <= '0;
      end else if (boundary) begin
        active <= 1'b1;
        fs_out <= 1'b1;
        wcnt   <= width_cfg;
        pcnt   <= period_cfg;
      end else begin
        pcnt   <= pcnt - 1'b1;
        fs_out <= (wcnt != '0);
        if (wcnt != '0) wcnt <= wcnt - 1'b1;
      end
    end
  end

  AST_RESET_LOW: assert property (@(posedge clk) rst |=> !fs_out); // R1
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !active |-> !fs_out); // R1
  AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tick && go && !active) |=> fs_out); // R2
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(fs_out)); // R5
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (tick && !go) |=> (!fs_out && !active)); // R8

endmodule

// File: tb/sim_fsync_gen.sv
module sim_fsync_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        run = 1'b0;
  logic        auto_en = 1'b0;
  logic [7:0]  width_cfg = '0;
  logic [11:0] period_cfg = '0;
  logic        fs_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fsync_gen u0 (
    .clk(clk), .rst(rst), .tick(tick), .run(run), .auto_en(auto_en),
    .width_cfg(width_cfg), .period_cfg(period_cfg), .fs_out(fs_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one tick; starts and ends just after a falling edge; gap idle clocks follow
  task automatic step(input int gap, input string req);
    logic held;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    held = fs_out;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk(fs_out == held, req, fs_out, held);
    end
  endtask

  task automatic clear_gen();
    run = 1'b0;
    step(0, "R8");
    chk(fs_out == 1'b0, "R8", fs_out, 0);
  endtask

  task automatic pattern(input int fw, input int fp, input int n, input int gap, input string req);
    int w, p;
    bit e;
    clear_gen();
    width_cfg = 8'(fw);
    period_cfg = 12'(fp);
    run = 1'b1;
    auto_en = 1'b1;
    w = fw + 1;
    p = fp + 1;
    for (int k = 0; k < n; k++) begin
      step(gap, "R5");
      e = ((k % p) < w);
      chk(fs_out == e, req, fs_out, e);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    run = 1'b1;
    auto_en = 1'b1;
    tick = 1'b1;
    repeat (3) @(negedge clk);
    chk(fs_out == 1'b0, "R1", fs_out, 0);
    tick = 1'b0;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(fs_out == 1'b0, "R1", fs_out, 0);
    width_cfg = 8'd1;
    period_cfg = 12'd15;
    step(0, "R2");
    chk(fs_out == 1'b1, "R2", fs_out, 1);
  endtask

  task automatic t_reconfig();
    bit e;
    clear_gen();
    width_cfg = 8'd1;
    period_cfg = 12'd7;
    run = 1'b1;
    auto_en = 1'b1;
    for (int k = 0; k < 28; k++) begin
      if (k == 3) begin
        width_cfg = 8'd3;
        period_cfg = 12'd4;
      end
      step(0, "R7");
      e = (k < 8) ? (k < 2) : (((k - 8) % 5) < 4);
      chk(fs_out == e, "R7", fs_out, e);
    end
  endtask

  task automatic t_disable();
    bit e;
    clear_gen();
    width_cfg = 8'd4;
    period_cfg = 12'd9;
    run = 1'b1;
    auto_en = 1'b1;
    repeat (2) step(0, "R8");
    chk(fs_out == 1'b1, "R8", fs_out, 1);
    run = 1'b0;
    step(0, "R8");
    chk(fs_out == 1'b0, "R8", fs_out, 0);
    repeat (3) step(0, "R8");
    chk(fs_out == 1'b0, "R8", fs_out, 0);
    run = 1'b1;
    for (int k = 0; k < 12; k++) begin
      step(0, "R8");
      e = ((k % 10) < 5);
      chk(fs_out == e, "R8", fs_out, e);
    end
    auto_en = 1'b0;
    step(0, "R8");
    chk(fs_out == 1'b0, "R8", fs_out, 0);
    auto_en = 1'b1;
    step(0, "R8");
    chk(fs_out == 1'b1, "R8", fs_out, 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    pattern(1, 15, 48, 0, "R3");
    pattern(2, 6, 21, 0, "R4");
    pattern(3, 9, 25, 3, "R5");
    pattern(0, 0, 10, 0, "R6");
    pattern(5, 3, 12, 1, "R6");
    pattern(255, 299, 620, 0, "R9");
    pattern(0, 4095, 4100, 0, "R9");
    t_reconfig();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule